// File: doc/BRIEF.md
# Load/Store Address and Lane Alignment Unit

This unit sits between the register read stage and the data memory port of a 32-bit big-endian core. For each memory request it adds a sign-extended 16-bit displacement to a base register value to form the effective address. It then works out which byte lanes of the aligned memory word the access touches. A store operand is moved into those lanes. A byte or halfword taken from the aligned read word is right-justified and sign- or zero-extended for the register file.

Lane order is big-endian: the byte at word offset 0 is the most significant byte of the memory word, and it is selected by byte-enable bit 3. A base register index of zero always reads as zero, so the displacement on its own then gives an absolute address. A zero displacement gives plain register-indirect addressing.

The unit has one register stage. A request offered in one cycle produces its results, together with a response-valid strobe, on the outputs in the next cycle.

Top module: `lsu_addr_align`

## Requirements
- R1: When `req_valid` is high, `eff_addr` one cycle later equals the base value plus the sign-extended `disp`, modulo 2^32, and `rsp_valid` is high in that cycle.
- R2: When `base_idx` is 0, the base is taken as zero whatever `base_val` holds, so `eff_addr` is the sign-extended displacement.
- R3: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. The word offset is `eff_addr[1:0]`. A byte at offset k sets only `byte_en[3-k]`. A halfword at offset 0 gives `byte_en` = 1100, and at offset 2 gives 0011. A word gives 1111.
- R4: `misaligned` rises in three cases: a halfword at an odd offset, a word at a nonzero offset, or size code 3. When it is high, `byte_en`, `store_lanes` and `load_result` are all zero.
- R5: For an aligned store (`req_store` = 1), the operand's low bytes are placed so that the operand's most significant byte sits at the addressed offset. Offset k occupies bits [31-8k -: 8]. All other lanes are zero, and `load_result` is zero.
- R6: For a signed byte load (`req_unsigned` = 0), the addressed byte of `mem_rdata` appears in bits 7:0, and bits 31:8 copy its bit 7.
- R7: For a signed halfword load at address A, the byte at A goes to bits 15:8 and the byte at A+1 goes to bits 7:0. Bits 31:16 copy bit 7 of the byte at A.
- R8: For unsigned byte and halfword loads (`req_unsigned` = 1), the bytes are placed in the same way as R6 and R7, and the upper bits are zero.
- R9: An aligned word load returns `mem_rdata` unchanged. For every load, `store_lanes` is zero.
- R10: Reset clears all outputs. In the cycle after a cycle with `req_valid` low, `rsp_valid`, `byte_en`, `misaligned`, `eff_addr`, `store_lanes` and `load_result` are all zero.
- R11: A zero displacement with a nonzero base index gives `eff_addr` equal to `base_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_unsigned | input | 1 | 1 = zero-extend sub-word loads |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| base_idx | input | 5 | Base register index; 0 forces a zero base |
| base_val | input | 32 | Base register contents |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Store operand, right-justified |
| mem_rdata | input | 32 | Aligned memory word for a load |
| rsp_valid | output | 1 | Results below belong to last cycle's request |
| eff_addr | output | 32 | Effective address |
| byte_en | output | 4 | Lane enables, bit 3 = offset 0 |
| store_lanes | output | 32 | Store operand moved into its lanes |
| load_result | output | 32 | Extended load value |
| misaligned | output | 1 | Alignment or size fault |

## Verification
The properties compare each response with the request inputs sampled one edge earlier. They therefore assume that every input is driven to a known value on each cycle after reset, and that `mem_rdata` belongs to the same cycle as its request. The bench changes every input only on the falling clock edge and never leaves a request field undriven. Its random phase draws all four size codes, every offset and both base-index cases, so the fault and zero-base properties are reached as well as the legal paths.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    parameter int XLEN   = 32;
    parameter int DISP_W = 16;
    parameter int RIDX_W = 5;

    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int EXT_W = XLEN - DISP_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [OFF_W-1:0] lane_off_t;
    typedef logic [OFF_W:0]   lane_cnt_t;

    typedef struct packed {
        logic       valid;
        word_t      addr;
        lane_mask_t be;
        word_t      wdata;
        word_t      rdata;
        logic       fault;
    } rsp_t;

    // Mask for an access at offset 0; bit LANES-1 is the lowest address.
    function automatic lane_mask_t size_mask(acc_size_e sz);
        lane_mask_t m;
        case (sz)
            SZ_BYTE: m = lane_mask_t'(1) << (LANES - 1);
            SZ_HALF: m = lane_mask_t'(3) << (LANES - 2);
            SZ_WORD: m = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic lane_cnt_t nbytes_of(acc_size_e sz);
        lane_cnt_t n;
        case (sz)
            SZ_BYTE: n = lane_cnt_t'(1);
            SZ_HALF: n = lane_cnt_t'(2);
            default: n = lane_cnt_t'(LANES);
        endcase
        return n;
    endfunction

    function automatic logic aligned_ok(acc_size_e sz, lane_off_t off);
        logic ok;
        case (sz)
            SZ_BYTE: ok = 1'b1;
            SZ_HALF: ok = ~off[0];
            SZ_WORD: ok = (off == '0);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int AW  = XLEN,
    parameter int DW  = DISP_W,
    parameter int IW  = RIDX_W
) (
    input  logic [IW-1:0] base_idx,
    input  logic [AW-1:0] base_val,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] ea
);
    localparam int XW = AW - DW;

    logic [AW-1:0] base_eff;
    logic [AW-1:0] disp_ext;

    always_comb begin
        // Index zero is hard-wired to read as zero.
        base_eff = (base_idx == '0) ? '0 : base_val;
        disp_ext = {{XW{disp[DW-1]}}, disp};
        ea       = base_eff + disp_ext;
    end
endmodule

// File: rtl/lsu_lane_ctl.sv
module lsu_lane_ctl
    import lsu_pkg::*;
(
    input  acc_size_e  size,
    input  lane_off_t  off,
    output lane_mask_t be,
    output logic       fault
);
    lane_mask_t shifted;

    always_comb begin
        shifted = size_mask(size) >> off;
        fault   = ~aligned_ok(size, off);
        be      = fault ? '0 : shifted;
    end
endmodule

// File: rtl/lsu_store_place.sv
module lsu_store_place
    import lsu_pkg::*;
(
    input  acc_size_e  size,
    input  lane_off_t  off,
    input  lane_mask_t lane_en,
    input  word_t      wdata,
    output word_t      placed
);
    lane_cnt_t nb;
    assign nb = nbytes_of(size);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // Lane j carries address offset K.
        localparam int K = LANES - 1 - j;
        lane_off_t  src;
        logic [7:0] lane_byte;

        always_comb begin
            // Operand byte at offset K, counted from its least significant end.
            src       = lane_off_t'(int'(nb) - 1 + int'(off) - K);
            lane_byte = lane_en[j] ? wdata[{src, 3'b000} +: 8] : 8'h00;
        end

        assign placed[8*j +: 8] = lane_byte;
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  acc_size_e size,
    input  lane_off_t off,
    input  logic      uns,
    input  word_t     rdata,
    output word_t     result
);
    lane_cnt_t nb;
    lane_off_t msb_lane;
    logic      sign;

    always_comb begin
        nb       = nbytes_of(size);
        msb_lane = lane_off_t'(LANES - 1) - off;
        sign     = rdata[{msb_lane, 3'b111}];
    end

    for (genvar p = 0; p < LANES; p++) begin : g_res
        lane_off_t  src_lane;
        logic [7:0] res_byte;

        always_comb begin
            // Result byte p comes from address offset off + nb-1-p.
            src_lane = lane_off_t'(LANES - 1 - (int'(off) + int'(nb) - 1 - p));
            if (p < int'(nb))
                res_byte = rdata[{src_lane, 3'b000} +: 8];
            else
                res_byte = uns ? 8'h00 : {8{sign}};
        end

        assign result[8*p +: 8] = res_byte;
    end
endmodule

// File: rtl/lsu_addr_align.sv
module lsu_addr_align
    import lsu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_store,
    input  logic                 req_unsigned,
    input  logic [1:0]           req_size,
    input  logic [RIDX_W-1:0]    base_idx,
    input  logic [XLEN-1:0]      base_val,
    input  logic [DISP_W-1:0]    disp,
    input  logic [XLEN-1:0]      store_data,
    input  logic [XLEN-1:0]      mem_rdata,
    output logic                 rsp_valid,
    output logic [XLEN-1:0]      eff_addr,
    output logic [LANES-1:0]     byte_en,
    output logic [XLEN-1:0]      store_lanes,
    output logic [XLEN-1:0]      load_result,
    output logic                 misaligned
);
    acc_size_e  size;
    word_t      ea;
    lane_off_t  off;
    lane_mask_t be_c;
    logic       fault_c;
    word_t      placed_c;
    word_t      loaded_c;
    rsp_t       nxt;
    rsp_t       rsp_q;

    assign size = acc_size_e'(req_size);
    assign off  = ea[OFF_W-1:0];

    lsu_agen #(.AW(XLEN), .DW(DISP_W), .IW(RIDX_W)) u_agen (
        .base_idx (base_idx),
        .base_val (base_val),
        .disp     (disp),
        .ea       (ea)
    );

    lsu_lane_ctl u_lanes (
        .size  (size),
        .off   (off),
        .be    (be_c),
        .fault (fault_c)
    );

    lsu_store_place u_place (
        .size    (size),
        .off     (off),
        .lane_en (be_c),
        .wdata   (store_data),
        .placed  (placed_c)
    );

    lsu_load_extract u_extract (
        .size   (size),
        .off    (off),
        .uns    (req_unsigned),
        .rdata  (mem_rdata),
        .result (loaded_c)
    );

    always_comb begin
        nxt       = '0;
        if (req_valid) begin
            nxt.valid = 1'b1;
            nxt.addr  = ea;
            nxt.be    = be_c;
            nxt.fault = fault_c;
            nxt.wdata = (req_store && !fault_c) ? placed_c : '0;
            nxt.rdata = (!req_store && !fault_c) ? loaded_c : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= nxt;
    end

    assign rsp_valid   = rsp_q.valid;
    assign eff_addr    = rsp_q.addr;
    assign byte_en     = rsp_q.be;
    assign store_lanes = rsp_q.wdata;
    assign load_result = rsp_q.rdata;
    assign misaligned  = rsp_q.fault;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_store,
    input logic                 req_unsigned,
    input logic [1:0]           req_size,
    input logic [RIDX_W-1:0]    base_idx,
    input logic [XLEN-1:0]      base_val,
    input logic [DISP_W-1:0]    disp,
    input logic                 rsp_valid,
    input logic [XLEN-1:0]      eff_addr,
    input logic [LANES-1:0]     byte_en,
    input logic [XLEN-1:0]      store_lanes,
    input logic [XLEN-1:0]      load_result,
    input logic                 misaligned
);
    function automatic logic [XLEN-1:0] lane_bits(logic [LANES-1:0] m);
        logic [XLEN-1:0] r;
        for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

    logic [XLEN-1:0] disp_sx;
    assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};

    p_addr_sum_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && ($past(base_idx) != '0) |-> eff_addr == $past(base_val) + $past(disp_sx));

    p_abs_base_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && ($past(base_idx) == '0) |-> eff_addr == $past(disp_sx));

    p_be_count_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !misaligned |-> $countones(byte_en) == (32'd1 << $past(req_size)));

    p_word_fault_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && ($past(req_size) == 2'd2) |-> misaligned == (eff_addr[OFF_W-1:0] != '0));

    p_fault_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> byte_en == '0 && store_lanes == '0 && load_result == '0);

    p_store_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(req_store) |-> (store_lanes & ~lane_bits(byte_en)) == '0 && load_result == '0);

    p_sbyte_ext_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !misaligned && !$past(req_store) && !$past(req_unsigned) && ($past(req_size) == 2'd0)
        |-> load_result[XLEN-1:8] == {(XLEN-8){load_result[7]}});

    p_zext_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !misaligned && !$past(req_store) && $past(req_unsigned) && ($past(req_size) < 2'd2)
        |-> load_result[XLEN-1:16] == '0);

    p_load_no_store_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !$past(req_store) |-> store_lanes == '0);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> byte_en == '0 && !misaligned && eff_addr == '0);

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));
endmodule

bind lsu_addr_align lsu_align_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_unsigned (req_unsigned),
    .req_size     (req_size),
    .base_idx     (base_idx),
    .base_val     (base_val),
    .disp         (disp),
    .rsp_valid    (rsp_valid),
    .eff_addr     (eff_addr),
    .byte_en      (byte_en),
    .store_lanes  (store_lanes),
    .load_result  (load_result),
    .misaligned   (misaligned)
);

// File: tb/sim_lsu_addr_align.sv
`timescale 1ns/1ps
module sim_lsu_addr_align;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [4:0]  base_idx = 5'd0;
    logic [31:0] base_val = 32'd0;
    logic [15:0] disp = 16'd0;
    logic [31:0] store_data = 32'd0, mem_rdata = 32'd0;
    logic        rsp_valid, misaligned;
    logic [31:0] eff_addr, store_lanes, load_result;
    logic [3:0]  byte_en;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    // previous request, held for the reference model
    bit          p_v = 0, p_st = 0, p_u = 0;
    int          p_sz = 0;
    logic [4:0]  p_idx = 0;
    logic [31:0] p_base = 0, p_sd = 0, p_rd = 0;
    logic [15:0] p_disp = 0;

    always #10 clk = ~clk;   // 50 MHz

    lsu_addr_align u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_unsigned(req_unsigned), .req_size(req_size), .base_idx(base_idx),
        .base_val(base_val), .disp(disp), .store_data(store_data),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .eff_addr(eff_addr),
        .byte_en(byte_en), .store_lanes(store_lanes), .load_result(load_result),
        .misaligned(misaligned)
    );

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Reference model applied to the request captured one cycle earlier.
    task automatic compare();
        logic [31:0] ea, e_wr, e_ld, base, piece;
        logic [3:0]  e_be;
        int          off, sh;
        bit          bad;
        string       atag, ltag;
        if (!p_v) begin
            chk("R10", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
            chk("R10", "eff_addr", eff_addr, 32'd0);
            chk("R10", "byte_en", {28'd0, byte_en}, 32'd0);
            chk("R10", "misaligned", {31'd0, misaligned}, 32'd0);
            chk("R10", "store_lanes", store_lanes, 32'd0);
            chk("R10", "load_result", load_result, 32'd0);
            return;
        end
        base = (p_idx == 0) ? 32'd0 : p_base;
        ea   = base + {{16{p_disp[15]}}, p_disp};
        off  = int'(ea[1:0]);
        bad  = (p_sz == 3) || (p_sz == 1 && off % 2 == 1) || (p_sz == 2 && off != 0);
        e_be = 4'd0; e_wr = 32'd0; e_ld = 32'd0;
        if (!bad) begin
            if (p_sz == 0)      e_be = 4'b1000 >> off;
            else if (p_sz == 1) e_be = 4'b1100 >> off;
            else                e_be = 4'b1111;
            if (p_st) begin
                if (p_sz == 0)      e_wr = (p_sd & 32'hFF)   << (8 * (3 - off));
                else if (p_sz == 1) e_wr = (p_sd & 32'hFFFF) << (8 * (2 - off));
                else                e_wr = p_sd;
            end else begin
                if (p_sz == 2) e_ld = p_rd;
                else begin
                    sh    = (p_sz == 0) ? 8 * (3 - off) : 8 * (2 - off);
                    piece = (p_rd >> sh) & ((p_sz == 0) ? 32'hFF : 32'hFFFF);
                    if (!p_u && p_sz == 0 && piece[7])  piece = piece | 32'hFFFF_FF00;
                    if (!p_u && p_sz == 1 && piece[15]) piece = piece | 32'hFFFF_0000;
                    e_ld = piece;
                end
            end
        end
        atag = (p_idx == 0) ? "R2" : (p_disp == 0) ? "R11" : "R1";
        if (p_st)           ltag = "R5";
        else if (p_sz == 2) ltag = "R9";
        else if (p_u)       ltag = "R8";
        else if (p_sz == 1) ltag = "R7";
        else                ltag = "R6";
        chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(atag, "eff_addr", eff_addr, ea);
        chk(bad ? "R4" : "R3", "byte_en", {28'd0, byte_en}, {28'd0, e_be});
        chk("R4", "misaligned", {31'd0, misaligned}, {31'd0, bad});
        chk(bad ? "R4" : (p_st ? "R5" : "R9"), "store_lanes", store_lanes, e_wr);
        chk(bad ? "R4" : ltag, "load_result", load_result, e_ld);
    endtask

    task automatic cyc(bit v, bit st, bit u, int sz, logic [4:0] idx,
                       logic [31:0] bv, logic [15:0] d, logic [31:0] sd, logic [31:0] rd);
        @(negedge clk);
        compare();
        req_valid = v; req_store = st; req_unsigned = u; req_size = 2'(sz);
        base_idx = idx; base_val = bv; disp = d; store_data = sd; mem_rdata = rd;
        p_v = v; p_st = st; p_u = u; p_sz = sz; p_idx = idx; p_base = bv;
        p_disp = d; p_sd = sd; p_rd = rd;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state (R10)
        cyc(0, 0, 0, 0, 5'd0, 32'd0, 16'd0, 32'd0, 32'd0);
        // R2: index zero ignores a nonzero base value
        cyc(1, 0, 0, 2, 5'd0, 32'hDEAD_BEEF, 16'h0200, 32'd0, 32'h1122_3344);
        // R11: zero displacement
        cyc(1, 0, 0, 2, 5'd7, 32'h0000_1000, 16'h0000, 32'd0, 32'hA5A5_5A5A);
        // R1: negative displacement wraps, positive crosses carry
        cyc(1, 1, 0, 2, 5'd3, 32'h0000_0010, 16'hFFF0, 32'hCAFE_F00D, 32'd0);
        cyc(1, 1, 0, 2, 5'd3, 32'hFFFF_FFFC, 16'h0008, 32'h0102_0304, 32'd0);
        // R3/R5: byte stores at every offset
        for (int k = 0; k < 4; k++)
            cyc(1, 1, 0, 0, 5'd1, 32'h100, 16'(k), 32'h1234_56AB, 32'd0);
        // R6/R8: byte loads signed and unsigned at every offset
        for (int k = 0; k < 4; k++) begin
            cyc(1, 0, 0, 0, 5'd1, 32'h200, 16'(k), 32'd0, 32'h80_7F_C3_01);
            cyc(1, 0, 1, 0, 5'd1, 32'h200, 16'(k), 32'd0, 32'h80_7F_C3_01);
        end
        // R7/R8: halfword loads at offsets 0 and 2
        cyc(1, 0, 0, 1, 5'd2, 32'h300, 16'h0000, 32'd0, 32'h9A_BC_12_34);
        cyc(1, 0, 0, 1, 5'd2, 32'h300, 16'h0002, 32'd0, 32'h12_34_F0_0F);
        cyc(1, 0, 1, 1, 5'd2, 32'h300, 16'h0000, 32'd0, 32'h9A_BC_12_34);
        cyc(1, 1, 0, 1, 5'd2, 32'h300, 16'h0002, 32'h7777_BEEF, 32'd0);
        // R4: odd halfword, unaligned words, illegal size
        cyc(1, 0, 0, 1, 5'd2, 32'h300, 16'h0001, 32'd0, 32'hFFFF_FFFF);
        for (int k = 1; k < 4; k++)
            cyc(1, 1, 0, 2, 5'd2, 32'h400, 16'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        cyc(1, 0, 0, 3, 5'd2, 32'h400, 16'h0000, 32'd0, 32'hFFFF_FFFF);
        // R10: idle after activity
        cyc(0, 1, 0, 2, 5'd9, 32'h500, 16'h0004, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 0, 5'd0, 32'h0, 16'h0, 32'h0, 32'h0);
        // mixed random traffic over all sizes, offsets and index cases
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] | r[1], r[2], r[3], int'(r[5:4]),
                (r[8:6] == 3'd0) ? 5'd0 : 5'($urandom),
                $urandom, (r[9]) ? 16'($urandom) : 16'($urandom % 8),
                $urandom, $urandom);
        end
        cyc(0, 0, 0, 0, 5'd0, 32'h0, 16'h0, 32'h0, 32'h0);
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule